// File: doc/BRIEF.md
# Dual-Role USB Port Role Controller

The block decides which role a dual-role USB port plays and when its PHY is powered. It follows four roles: undefined (after reset), B-idle, B-peripheral and A-host. Its inputs are a VBUS-valid indication that can be taken from the A-valid or the B-valid comparator, a host-cable-present level and the result of an external charger-classification sequencer. When VBUS appears it starts that sequencer. It enables the PHY only for a data-capable charger or a host cable, and it emits a one-cycle cable event whenever the attach level changes.

The block does not track its inputs continuously. It evaluates them in steps. A step happens on a periodic tick (nominally 2 s), on a latched rising edge of the selected VBUS-valid, on the cycle after a classification result arrives, and on the cycle after a peripheral loses VBUS. A static host-only input parks the block. While it is high, the host controller owns the PHY.

Top module: `otg_role_ctrl`

## Requirements
- R1: After reset `role_o` is 0 (undefined), `phy_pwr_o` is 1, and `chg_req_o` and `cable_evt_o` are 0.
- R2: The first step from undefined moves to B-idle (1) and turns the PHY off if VBUS is absent. B-idle is then evaluated in the same step.
- R3: In B-idle a present host cable wins over VBUS. The block enters A-host (3) with the PHY on, and A-host is entered only when the host cable was present.
- R4: In B-idle with VBUS present and no classification yet, `chg_req_o` rises and stays high until a `chg_done_i` pulse. The block latches `chg_type_i` with it.
- R5: Classification codes are 1 = standard port, 2 = charging downstream port, 3 = dedicated charger. Codes 1 and 2 turn the PHY on and enter B-peripheral (2). Code 3 keeps the PHY off in B-idle.
- R6: Every change of the attach level gives a one-cycle `cable_evt_o`. It carries `cable_attach_o` (1 attach, 0 detach) and `cable_type_o`, which is the classified code and is never 0.
- R7: In B-peripheral, loss of VBUS clears the classification, turns the PHY off and returns to B-idle. The next step runs on the following cycle, so the detach event appears one cycle after the role change.
- R8: In A-host, removal of the host cable returns to B-idle with the PHY off. In B-peripheral the host cable is ignored while VBUS stays present.
- R9: A step is taken every `TICK_CYCLES` clock cycles.
- R10: A rising edge of the selected VBUS-valid latches a pending flag. The flag forces a step on the next cycle and is cleared by that step, so `chg_req_o` rises two cycles after the edge.
- R11: `vbus_sel_i` = 1 reads VBUS from `avalid_i` and 0 from `bvalid_i`. The unselected input has no effect.
- R12: While `host_only_i` is 1, the block holds undefined with the PHY on and produces no request and no event.
- R13: In B-idle with VBUS absent the classification is cleared, so every new attach runs a fresh classification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_only_i | input | 1 | Static host-only mode, parks the block |
| vbus_sel_i | input | 1 | 1: VBUS from A-valid, 0: from B-valid |
| avalid_i | input | 1 | A-valid comparator level |
| bvalid_i | input | 1 | B-valid comparator level |
| host_cable_i | input | 1 | Host cable present |
| chg_req_o | output | 1 | Charger classification request, held until done |
| chg_done_i | input | 1 | One-cycle classification result strobe |
| chg_type_i | input | 2 | Classification code, 1 SDP, 2 CDP, 3 DCP |
| phy_pwr_o | output | 1 | PHY power enable |
| role_o | output | 2 | 0 undefined, 1 B-idle, 2 B-peripheral, 3 A-host |
| cable_evt_o | output | 1 | One-cycle cable event |
| cable_attach_o | output | 1 | Attach level carried by the event |
| cable_type_o | output | 2 | Cable type carried by the event |

## Verification
Directed sequences exercise the role paths one at a time. The VBUS edge separates the interrupt-driven step from the periodic one. The peripheral drop shows the immediate re-step. The A-valid against B-valid pattern separates the two comparator sources. The dedicated-charger attach shows that the event is reported while the PHY stays dark. Random phases then hold combinations of host cable, both comparator levels, selector and classification code for several ticks each. A bench model iterates the stepping rules to a fixed point and predicts the final role, PHY power and the number and content of cable events. This separates priority and history effects, for example a host cable that arrives during a peripheral session, or a repeated attach that must reclassify.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;
  typedef enum logic [1:0] {
    ROLE_UNDEF    = 2'd0,
    ROLE_B_IDLE   = 2'd1,
    ROLE_B_PERIPH = 2'd2,
    ROLE_A_HOST   = 2'd3
  } role_e;

  typedef enum logic [1:0] {
    CHG_NONE = 2'd0,
    CHG_SDP  = 2'd1,
    CHG_CDP  = 2'd2,
    CHG_DCP  = 2'd3
  } chg_e;

  typedef enum logic [1:0] {
    DET_IDLE = 2'd0,
    DET_RUN  = 2'd1,
    DET_DONE = 2'd2
  } det_e;
endpackage

// File: rtl/otg_tick_gen.sv
module otg_tick_gen #(
  parameter int unsigned TICK_CYCLES = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i)           cnt_q <= '0;
    else if (cnt_q == LAST)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/otg_vbus_edge.sv
module otg_vbus_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  input  logic avalid_i,
  input  logic bvalid_i,
  input  logic ack_i,
  output logic vbus_o,
  output logic pend_o
);
  logic vbus, vbus_q, pend_q, rise;

  assign vbus = sel_i ? avalid_i : bvalid_i;
  assign rise = en_i && vbus && !vbus_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vbus_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vbus_q <= vbus;
      // a new edge wins over the clear of the previous one
      if (!en_i)      pend_q <= 1'b0;
      else if (rise)  pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign vbus_o = vbus;
  assign pend_o = pend_q;
endmodule

// File: rtl/otg_role_fsm.sv
module otg_role_fsm
  import otg_role_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  eval_i,
  input  logic  vbus_i,
  input  logic  host_i,
  input  logic  chg_done_i,
  input  chg_e  chg_type_i,
  output logic  ack_o,
  output logic  chg_req_o,
  output logic  phy_pwr_o,
  output role_e role_o,
  output logic  evt_o,
  output logic  evt_attach_o,
  output chg_e  evt_type_o
);
  role_e role_q, role_d, st_c;
  det_e  det_q, det_d;
  chg_e  type_q, type_d, evt_type_q, evt_type_d;
  logic  phy_q, phy_d, att_q, att_d, redo_q, redo_d;
  logic  evt_q, evt_d, evt_att_q, evt_att_d;
  logic  go;

  assign go = eval_i || redo_q;

  always_comb begin
    role_d     = role_q;
    phy_d      = phy_q;
    det_d      = det_q;
    type_d     = type_q;
    att_d      = att_q;
    evt_d      = 1'b0;
    evt_att_d  = evt_att_q;
    evt_type_d = evt_type_q;
    redo_d     = 1'b0;
    st_c       = role_q;

    if (det_q == DET_RUN && chg_done_i) begin
      det_d  = DET_DONE;
      type_d = chg_type_i;
      redo_d = 1'b1;
    end

    if (go) begin
      if (st_c == ROLE_UNDEF) begin
        st_c   = ROLE_B_IDLE;
        role_d = ROLE_B_IDLE;
        if (!vbus_i) phy_d = 1'b0;
      end
      case (st_c)
        ROLE_B_IDLE: begin
          if (host_i) begin
            role_d = ROLE_A_HOST;
            phy_d  = 1'b1;
          end else if (vbus_i) begin
            if (det_q == DET_IDLE) begin
              det_d = DET_RUN;
            end else if (det_q == DET_DONE && type_q != CHG_NONE) begin
              if (type_q == CHG_DCP) begin
                phy_d = 1'b0;
              end else begin
                phy_d  = 1'b1;
                role_d = ROLE_B_PERIPH;
              end
              if (!att_q) begin
                att_d      = 1'b1;
                evt_d      = 1'b1;
                evt_att_d  = 1'b1;
                evt_type_d = type_q;
              end
            end
          end else begin
            det_d  = DET_IDLE;
            type_d = CHG_NONE;
            if (att_q) begin
              att_d     = 1'b0;
              evt_d     = 1'b1;
              evt_att_d = 1'b0;
            end
          end
        end
        ROLE_B_PERIPH: begin
          if (!vbus_i) begin
            det_d  = DET_IDLE;
            type_d = CHG_NONE;
            phy_d  = 1'b0;
            role_d = ROLE_B_IDLE;
            redo_d = 1'b1;
          end
        end
        ROLE_A_HOST: begin
          if (!host_i) begin
            role_d = ROLE_B_IDLE;
            phy_d  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      role_q <= ROLE_UNDEF;   phy_q <= 1'b1;       det_q <= DET_IDLE;
      type_q <= CHG_NONE;     att_q <= 1'b0;       redo_q <= 1'b0;
      evt_q <= 1'b0;          evt_att_q <= 1'b0;   evt_type_q <= CHG_NONE;
    end else if (!en_i) begin
      role_q <= ROLE_UNDEF;   phy_q <= 1'b1;       det_q <= DET_IDLE;
      type_q <= CHG_NONE;     att_q <= 1'b0;       redo_q <= 1'b0;
      evt_q <= 1'b0;          evt_att_q <= 1'b0;   evt_type_q <= CHG_NONE;
    end else begin
      role_q <= role_d;       phy_q <= phy_d;      det_q <= det_d;
      type_q <= type_d;       att_q <= att_d;      redo_q <= redo_d;
      evt_q <= evt_d;         evt_att_q <= evt_att_d; evt_type_q <= evt_type_d;
    end
  end

  assign ack_o        = go;
  assign chg_req_o    = (det_q == DET_RUN);
  assign phy_pwr_o    = phy_q;
  assign role_o       = role_q;
  assign evt_o        = evt_q;
  assign evt_attach_o = evt_att_q;
  assign evt_type_o   = evt_type_q;
endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
  import otg_role_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 200_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       host_only_i,
  input  logic       vbus_sel_i,
  input  logic       avalid_i,
  input  logic       bvalid_i,
  input  logic       host_cable_i,
  output logic       chg_req_o,
  input  logic       chg_done_i,
  input  logic [1:0] chg_type_i,
  output logic       phy_pwr_o,
  output logic [1:0] role_o,
  output logic       cable_evt_o,
  output logic       cable_attach_o,
  output logic [1:0] cable_type_o
);
  logic  en, tick, vbus, pend, ack;
  role_e role_w;
  chg_e  evt_type_w;

  assign en = !host_only_i;

  otg_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_o (tick)
  );

  otg_vbus_edge u_vbus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .sel_i    (vbus_sel_i),
    .avalid_i (avalid_i),
    .bvalid_i (bvalid_i),
    .ack_i    (ack),
    .vbus_o   (vbus),
    .pend_o   (pend)
  );

  otg_role_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .eval_i       (tick || pend),
    .vbus_i       (vbus),
    .host_i       (host_cable_i),
    .chg_done_i   (chg_done_i),
    .chg_type_i   (chg_e'(chg_type_i)),
    .ack_o        (ack),
    .chg_req_o    (chg_req_o),
    .phy_pwr_o    (phy_pwr_o),
    .role_o       (role_w),
    .evt_o        (cable_evt_o),
    .evt_attach_o (cable_attach_o),
    .evt_type_o   (evt_type_w)
  );

  assign role_o       = role_w;
  assign cable_type_o = evt_type_w;
endmodule

// File: rtl/otg_role_ctrl_chk.sv
module otg_role_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_only_i,
  input logic       host_cable_i,
  input logic       chg_req_o,
  input logic       phy_pwr_o,
  input logic [1:0] role_o,
  input logic       cable_evt_o,
  input logic [1:0] cable_type_o
);
  p_phy_on_host_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    role_o == 2'd3 |-> phy_pwr_o);

  p_host_entry_cable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_o == 2'd3 && $past(role_o) != 2'd3) |-> $past(host_cable_i));

  p_req_from_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_req_o) |-> role_o == 2'd1);

  p_phy_on_periph_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    role_o == 2'd2 |-> phy_pwr_o);

  p_evt_type_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cable_evt_o |-> cable_type_o != 2'd0);

  p_phy_off_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_pwr_o) |-> role_o == 2'd1);

  p_host_only_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_only_i |=> (role_o == 2'd0 && phy_pwr_o && !cable_evt_o && !chg_req_o));
endmodule

bind otg_role_ctrl otg_role_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_only_i  (host_only_i),
  .host_cable_i (host_cable_i),
  .chg_req_o    (chg_req_o),
  .phy_pwr_o    (phy_pwr_o),
  .role_o       (role_o),
  .cable_evt_o  (cable_evt_o),
  .cable_type_o (cable_type_o)
);

// File: tb/otg_role_ctrl_tb_top.sv
module otg_role_ctrl_tb_top;
  localparam int TICK = 64;

  logic clk = 1'b0;
  logic rst_ni, host_only, vbus_sel, avalid, bvalid, host_cable;
  logic chg_req, chg_done, phy_pwr, cable_evt, cable_attach;
  logic [1:0] chg_type, role, cable_type;

  int n_chk = 0, n_fail = 0;
  int evt_cnt = 0, req_rises = 0, last_att = 0, last_type = 0;
  int cur_type = 1;
  bit finished = 0;

  // bench model state
  int m_role, m_det, m_att, m_phy, m_nevt, m_last_att, m_last_type;

  always #5 clk = ~clk;

  otg_role_ctrl #(.TICK_CYCLES(TICK)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .host_only_i(host_only), .vbus_sel_i(vbus_sel),
    .avalid_i(avalid), .bvalid_i(bvalid), .host_cable_i(host_cable),
    .chg_req_o(chg_req), .chg_done_i(chg_done), .chg_type_i(chg_type),
    .phy_pwr_o(phy_pwr), .role_o(role), .cable_evt_o(cable_evt),
    .cable_attach_o(cable_attach), .cable_type_o(cable_type)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // event and request monitor
  initial begin
    bit prev_req = 0;
    forever begin
      @(negedge clk);
      if (cable_evt) begin
        evt_cnt++;
        last_att = int'(cable_attach);
        last_type = int'(cable_type);
      end
      if (chg_req && !prev_req) req_rises++;
      prev_req = chg_req;
    end
  end

  // charger classification responder
  initial begin
    chg_done = 0;
    chg_type = 0;
    forever begin
      @(negedge clk);
      if (chg_req && !chg_done) begin
        repeat (3) @(negedge clk);
        if (chg_req) begin
          chg_done = 1;
          chg_type = 2'(cur_type);
          @(negedge clk);
          chg_done = 0;
        end
      end
    end
  end

  function automatic void model_reset();
    m_role = 0; m_det = 0; m_att = 0; m_phy = 1;
  endfunction

  // iterate the stepping rules to a fixed point
  function automatic void model_settle(bit h, bit v, int t);
    for (int i = 0; i < 6; i++) begin
      case (m_role)
        0: begin m_role = 1; if (!v) m_phy = 0; end
        1: begin
          if (h) begin m_role = 3; m_phy = 1; end
          else if (v) begin
            if (m_det == 0) m_det = t;
            if (m_det == 1 || m_det == 2) begin m_role = 2; m_phy = 1; end
            else m_phy = 0;
            if (!m_att) begin
              m_att = 1; m_nevt++; m_last_att = 1; m_last_type = m_det;
            end
          end else begin
            m_det = 0;
            if (m_att) begin m_att = 0; m_nevt++; m_last_att = 0; end
          end
        end
        2: if (!v) begin m_det = 0; m_phy = 0; m_role = 1; end
        default: if (!h) begin m_role = 1; m_phy = 0; end
      endcase
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e0, r0, w;
    void'($urandom(32'd4711));
    rst_ni = 0; host_only = 0; vbus_sel = 0; avalid = 0; bvalid = 0; host_cable = 0;
    cyc(3);
    chk("R1", "role", int'(role), 0);
    chk("R1", "phy", int'(phy_pwr), 1);
    chk("R1", "req", int'(chg_req), 0);
    chk("R1", "evt", int'(cable_evt), 0);
    rst_ni = 1;

    // R2: first step with VBUS absent
    cyc(TICK + 4);
    chk("R2", "role", int'(role), 1);
    chk("R2", "phy", int'(phy_pwr), 0);

    // R10, R4, R5: VBUS edge, standard port
    cur_type = 1; e0 = evt_cnt;
    bvalid = 1;
    cyc(1);
    chk("R10", "req one cycle after edge", int'(chg_req), 0);
    cyc(1);
    chk("R10", "req two cycles after edge", int'(chg_req), 1);
    cyc(10);
    chk("R4", "req released", int'(chg_req), 0);
    chk("R5", "role sdp", int'(role), 2);
    chk("R5", "phy sdp", int'(phy_pwr), 1);
    chk("R6", "attach evt count", evt_cnt - e0, 1);
    chk("R6", "attach level", last_att, 1);
    chk("R6", "attach type", last_type, 1);

    // R8: peripheral ignores the host cable
    host_cable = 1;
    cyc(2 * TICK);
    chk("R8", "periph holds with host cable", int'(role), 2);
    host_cable = 0;

    // R7: VBUS loss in peripheral, detach one cycle after role change
    bvalid = 0; e0 = evt_cnt; w = 0;
    while (role == 2 && w < 2 * TICK) begin cyc(1); w++; end
    chk("R7", "role", int'(role), 1);
    chk("R7", "phy", int'(phy_pwr), 0);
    chk("R7", "no evt yet", int'(cable_evt), 0);
    cyc(1);
    chk("R7", "detach evt", int'(cable_evt), 1);
    chk("R7", "detach level", int'(cable_attach), 0);
    chk("R6", "detach type", int'(cable_type), 1);

    // R13, R5: new attach reclassifies, dedicated charger
    cur_type = 3; r0 = req_rises; e0 = evt_cnt;
    cyc(3);
    bvalid = 1;
    cyc(12);
    chk("R13", "new classification", req_rises - r0, 1);
    chk("R5", "role dcp", int'(role), 1);
    chk("R5", "phy dcp", int'(phy_pwr), 0);
    chk("R5", "dcp reported", evt_cnt - e0, 1);
    chk("R6", "dcp type", last_type, 3);

    // R3, R9: host cable picked up by a periodic step
    host_cable = 1; w = 0;
    while (role != 3 && w < 3 * TICK) begin cyc(1); w++; end
    chk("R3", "role host", int'(role), 3);
    chk("R3", "phy host", int'(phy_pwr), 1);
    chk("R9", "step within tick", int'(w <= TICK + 2), 1);

    // R8: host cable removed
    host_cable = 0;
    cyc(TICK + 4);
    chk("R8", "role after removal", int'(role), 1);
    chk("R8", "phy after removal", int'(phy_pwr), 0);
    bvalid = 0;
    cyc(TICK + 4);
    chk("R6", "detach level", last_att, 0);

    // R11: selector
    vbus_sel = 1; r0 = req_rises; e0 = evt_cnt;
    bvalid = 1;
    cyc(3 * TICK);
    chk("R11", "bvalid ignored req", req_rises - r0, 0);
    chk("R11", "bvalid ignored role", int'(role), 1);
    chk("R11", "bvalid ignored evt", evt_cnt - e0, 0);
    cur_type = 2;
    avalid = 1;
    cyc(2);
    chk("R11", "avalid selected", int'(chg_req), 1);
    cyc(10);
    chk("R5", "role cdp", int'(role), 2);
    avalid = 0; bvalid = 0;
    cyc(2 * TICK + 4);
    chk("R11", "role after avalid loss", int'(role), 1);

    // R12: host-only mode
    host_only = 1; r0 = req_rises; e0 = evt_cnt;
    cyc(2);
    chk("R12", "role", int'(role), 0);
    chk("R12", "phy", int'(phy_pwr), 1);
    avalid = 1; bvalid = 1; host_cable = 1;
    cyc(TICK);
    host_cable = 0;
    cyc(2 * TICK);
    chk("R12", "no req", req_rises - r0, 0);
    chk("R12", "no evt", evt_cnt - e0, 0);
    chk("R12", "role held", int'(role), 0);
    avalid = 0; bvalid = 0; vbus_sel = 0;
    cyc(2);
    host_only = 0;
    model_reset();
    m_nevt = 0;

    // random phase
    for (int s = 0; s < 40; s++) begin
      int n0, ev0, t;
      bit h, v;
      n0 = m_nevt; ev0 = evt_cnt;
      h = ($urandom % 3) == 0;
      vbus_sel = 1'($urandom % 2);
      avalid = 1'($urandom % 2);
      bvalid = 1'($urandom % 2);
      t = 1 + int'($urandom % 3);
      cur_type = t;
      host_cable = h;
      v = vbus_sel ? avalid : bvalid;
      cyc(6 * TICK + 20);
      model_settle(h, v, t);
      chk("R5", "random role", int'(role), m_role);
      chk("R3", "random phy", int'(phy_pwr), m_phy);
      chk("R6", "random evt count", evt_cnt - ev0, m_nevt - n0);
      if (m_nevt != n0) begin
        chk("R6", "random evt level", last_att, m_last_att);
        chk("R13", "random evt type", last_type, m_last_type);
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule